// File: doc/BRIEF.md
# Dual-Mode Latch/Register Bus Driver

This block carries an 18-bit data word from an input bus to an output bus through one storage element per bit. A run-time mode input selects how that element behaves. With the mode input high, the element is transparent and the output tracks the input. With it low, the element becomes an edge-triggered register, loaded on each rising edge of a separate capture-clock input. A separate disable input turns the output drive off without touching the stored data.

Every control and data input is sampled on a fast system clock. A rising edge of the capture clock is found by comparing two consecutive samples. The tri-state output is modelled as two vectors: a value and a per-bit drive enable, with 1 meaning driven. The block contains no internal tristate nets. A pad ring or a bus model turns the pair into real high-impedance behaviour.

Top module: `busdrv_latchreg`

## Requirements
- R1: While reset is asserted, and after it is released until new data arrives, `y_drv` is all zeros and `y_val` is all zeros.
- R2: When `out_dis` is sampled high, `y_drv` is all zeros in the next cycle, whatever `lat_en`, `cap_clk` and `a_in` do.
- R3: When `out_dis` is sampled low, `y_drv` is all ones in the next cycle and `y_val` shows the stored word.
- R4: With `lat_en` high, `y_val` equals the `a_in` sampled two system cycles earlier, and `cap_clk` has no effect.
- R5: With `lat_en` low, a `cap_clk` sample of 1 that follows a sample of 0 stores the `a_in` sampled in the same cycle. That word appears on `y_val` two system cycles after that sample.
- R6: With `lat_en` low and `cap_clk` steady at either level, `y_val` does not change when `a_in` changes.
- R7: When `lat_en` falls, the stored word is the last `a_in` sampled while `lat_en` was high. This holds even if `cap_clk` is high across the fall.
- R8: The storage keeps loading while `out_dis` is high. The loaded word is on `y_val` in the first cycle in which drive returns.
- R9: A falling edge of `cap_clk` (sample 1 followed by sample 0) does not load the storage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_sys | input | 1 | System clock; samples all inputs |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| a_in | input | 18 | Input data bus |
| lat_en | input | 1 | 1 = transparent mode, 0 = edge-register mode |
| cap_clk | input | 1 | Capture clock for register mode, sampled as data |
| out_dis | input | 1 | 1 = output drive off (high impedance) |
| y_val | output | 18 | Output value bus |
| y_drv | output | 18 | Per-bit drive enable, 1 = driven |

## Verification
Every cycle, the checker ties the drive vector to the previous sample of the disable input. It also ties the output word to the input sampled two cycles earlier whenever that sample saw transparent mode or a capture-clock rise, and it requires the word to stay stable when neither applies. The bench scenarios cover behaviour that spans several cycles and that a single property cannot state. These are the word retained across a fall of `lat_en` while `cap_clk` is high, data loaded while the outputs are off and then seen once drive returns, and the reset state before any data has arrived.

// File: rtl/lr_pkg.sv
package lr_pkg;
  localparam int LR_WIDTH = 18;

  typedef enum logic {
    MODE_EDGE  = 1'b0,
    MODE_TRANS = 1'b1
  } lr_mode_e;
endpackage

// File: rtl/lr_rst_sync.sv
module lr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/lr_in_sample.sv
module lr_in_sample #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic         lat_en,
  input  logic         cap_clk,
  input  logic         out_dis,
  output logic [W-1:0] a_q,
  output lr_pkg::lr_mode_e mode_q,
  output logic         rise,
  output logic         dis_q
);
  logic ck_q, ck_prev_q;
  logic [W-1:0] a_d;
  logic ck_d, ck_prev_d, le_d, dis_d;
  logic le_q;

  always_comb begin
    a_d       = a_in;
    le_d      = lat_en;
    ck_d      = cap_clk;
    ck_prev_d = ck_q;
    dis_d     = out_dis;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q       <= '0;
      le_q      <= 1'b0;
      ck_q      <= 1'b0;
      ck_prev_q <= 1'b0;
      dis_q     <= 1'b1;
    end else begin
      a_q       <= a_d;
      le_q      <= le_d;
      ck_q      <= ck_d;
      ck_prev_q <= ck_prev_d;
      dis_q     <= dis_d;
    end
  end

  assign mode_q = le_q ? lr_pkg::MODE_TRANS : lr_pkg::MODE_EDGE;
  assign rise   = ck_q & ~ck_prev_q;
endmodule

// File: rtl/lr_store_bank.sv
module lr_store_bank #(
  parameter int W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     a_q,
  input  lr_pkg::lr_mode_e mode_q,
  input  logic             rise,
  output logic [W-1:0]     store_q
);
  logic load_en;

  always_comb begin
    unique case (mode_q)
      lr_pkg::MODE_TRANS: load_en = 1'b1;
      default:            load_en = rise;
    endcase
  end

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic bit_d;
    always_comb begin
      bit_d = store_q[b];
      if (load_en) bit_d = a_q[b];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) store_q[b] <= 1'b0;
      else        store_q[b] <= bit_d;
    end
  end
endmodule

// File: rtl/lr_out_gate.sv
module lr_out_gate #(
  parameter int W = 18
) (
  input  logic [W-1:0] store_q,
  input  logic         dis_q,
  output logic [W-1:0] y_val,
  output logic [W-1:0] y_drv
);
  always_comb begin
    y_val = store_q;
    y_drv = {W{~dis_q}};
  end
endmodule

// File: rtl/busdrv_latchreg.sv
module busdrv_latchreg #(
  parameter int W = lr_pkg::LR_WIDTH
) (
  input  logic         clk_sys,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic         lat_en,
  input  logic         cap_clk,
  input  logic         out_dis,
  output logic [W-1:0] y_val,
  output logic [W-1:0] y_drv
);
  logic             rst_sync_n;
  logic [W-1:0]     a_q;
  lr_pkg::lr_mode_e mode_q;
  logic             rise;
  logic             dis_q;
  logic [W-1:0]     store_q;

  lr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk_sys), .rst_n(rst_n), .rst_n_out(rst_sync_n)
  );

  lr_in_sample #(.W(W)) u_smp (
    .clk(clk_sys), .rst_n(rst_sync_n), .a_in(a_in), .lat_en(lat_en),
    .cap_clk(cap_clk), .out_dis(out_dis), .a_q(a_q), .mode_q(mode_q),
    .rise(rise), .dis_q(dis_q)
  );

  lr_store_bank #(.W(W)) u_bank (
    .clk(clk_sys), .rst_n(rst_sync_n), .a_q(a_q), .mode_q(mode_q),
    .rise(rise), .store_q(store_q)
  );

  lr_out_gate #(.W(W)) u_out (
    .store_q(store_q), .dis_q(dis_q), .y_val(y_val), .y_drv(y_drv)
  );
endmodule

// File: rtl/lr_chk.sv
module lr_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst_ok,
  input logic [W-1:0] a_in,
  input logic         lat_en,
  input logic         cap_clk,
  input logic         out_dis,
  input logic [W-1:0] y_val,
  input logic [W-1:0] y_drv
);
  logic [1:0] age_q;
  logic       warm;

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok)            age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end
  assign warm = (age_q == 2'd3);

  AST_DRIVE_OFF: assert property (@(posedge clk) disable iff (!rst_ok)
    warm && $past(out_dis) |-> y_drv == '0);                          // R2
  AST_DRIVE_ON: assert property (@(posedge clk) disable iff (!rst_ok)
    warm && !$past(out_dis) |-> y_drv == '1);                         // R3
  AST_TRANS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_ok)
    warm && $past(lat_en, 2) |-> y_val == $past(a_in, 2));            // R4
  AST_EDGE_LOAD: assert property (@(posedge clk) disable iff (!rst_ok)
    warm && !$past(lat_en, 2) && $past(cap_clk, 2) && !$past(cap_clk, 3)
    |-> y_val == $past(a_in, 2));                                     // R5
  AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_ok)
    warm && !$past(lat_en, 2) && ($past(cap_clk, 2) == $past(cap_clk, 3))
    |-> $stable(y_val));                                              // R6
  AST_NO_FALL_LOAD: assert property (@(posedge clk) disable iff (!rst_ok)
    warm && !$past(lat_en, 2) && !$past(cap_clk, 2) && $past(cap_clk, 3)
    |-> $stable(y_val));                                              // R9
endmodule

bind busdrv_latchreg lr_chk #(.W(W)) u_chk (
  .clk(clk_sys), .rst_ok(rst_sync_n), .a_in(a_in), .lat_en(lat_en),
  .cap_clk(cap_clk), .out_dis(out_dis), .y_val(y_val), .y_drv(y_drv)
);

// File: tb/sim_busdrv_latchreg.sv
`timescale 1ns/1ps
module sim_busdrv_latchreg;
  localparam int W = 18;
  logic         clk_sys = 1'b0;
  logic         rst_n;
  logic [W-1:0] a_in;
  logic         lat_en, cap_clk, out_dis;
  logic [W-1:0] y_val, y_drv;
  int total = 0;
  int bad = 0;

  always #5 clk_sys = ~clk_sys;

  busdrv_latchreg #(.W(W)) u0 (
    .clk_sys(clk_sys), .rst_n(rst_n), .a_in(a_in), .lat_en(lat_en),
    .cap_clk(cap_clk), .out_dis(out_dis), .y_val(y_val), .y_drv(y_drv)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk_sys);
  endtask

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; a_in = 18'h3A5C1; lat_en = 1'b1; cap_clk = 1'b0; out_dis = 1'b0;
    tick(3);
    chk("R1 drv in reset", y_drv, '0);
    chk("R1 val in reset", y_val, '0);
    lat_en = 1'b0; out_dis = 1'b1;
    rst_n = 1'b1;
    tick(5);
    chk("R1 drv after release", y_drv, '0);
    chk("R1 val after release", y_val, '0);
  endtask

  task automatic t_transparent();
    out_dis = 1'b0; lat_en = 1'b1; a_in = 18'h2AAAA;
    tick(2);
    chk("R3 drive on", y_drv, '1);
    chk("R4 follow pattern A", y_val, 18'h2AAAA);
    a_in = 18'h15555; cap_clk = 1'b1;
    tick(2);
    chk("R4 follow pattern B, clk high", y_val, 18'h15555);
    a_in = 18'h00001; cap_clk = 1'b0;
    tick(2);
    chk("R4 follow single bit, clk fall", y_val, 18'h00001);
    a_in = 18'h3FFFF;
    tick(2);
    chk("R4 follow all ones", y_val, 18'h3FFFF);
  endtask

  task automatic t_edge();
    a_in = 18'h12345; lat_en = 1'b1; cap_clk = 1'b0;
    tick(2);
    lat_en = 1'b0;
    tick(2);
    a_in = 18'h0F0F0;
    tick(3);
    chk("R6 hold with clk low", y_val, 18'h12345);
    a_in = 18'h3C3C3; cap_clk = 1'b1;
    tick(2);
    chk("R5 capture on rise", y_val, 18'h3C3C3);
    a_in = 18'h00F00;
    tick(3);
    chk("R6 hold with clk high", y_val, 18'h3C3C3);
    a_in = 18'h2BEEF; cap_clk = 1'b0;
    tick(3);
    chk("R9 no load on fall", y_val, 18'h3C3C3);
    cap_clk = 1'b1;
    tick(2);
    chk("R5 second rise loads", y_val, 18'h2BEEF);
  endtask

  task automatic t_le_fall();
    cap_clk = 1'b1; lat_en = 1'b1; a_in = 18'h1D00D;
    tick(2);
    chk("R4 transparent with clk high", y_val, 18'h1D00D);
    lat_en = 1'b0; a_in = 18'h26262;
    tick(3);
    chk("R7 retained after LE fall", y_val, 18'h1D00D);
    a_in = 18'h11111;
    tick(2);
    chk("R7 still retained", y_val, 18'h1D00D);
    cap_clk = 1'b0; tick(1);
    lat_en = 1'b1; a_in = 18'h0ABCD;
    tick(2);
    chk("R4 back to transparent", y_val, 18'h0ABCD);
  endtask

  task automatic t_disable();
    out_dis = 1'b1; lat_en = 1'b0; cap_clk = 1'b0;
    tick(1);
    chk("R2 drive off", y_drv, '0);
    a_in = 18'h35A5A; cap_clk = 1'b1;
    tick(3);
    chk("R2 drive off while loading", y_drv, '0);
    out_dis = 1'b0;
    tick(1);
    chk("R8 drive returns", y_drv, '1);
    chk("R8 word loaded while off", y_val, 18'h35A5A);
    out_dis = 1'b1; lat_en = 1'b1; a_in = 18'h07E07;
    tick(3);
    chk("R2 drive off in transparent", y_drv, '0);
    out_dis = 1'b0;
    tick(1);
    chk("R8 latched word while off", y_val, 18'h07E07);
  endtask

  initial begin
    t_reset();
    t_transparent();
    t_edge();
    t_le_fall();
    t_disable();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule